// File: doc/BRIEF.md
# Serial Host Register Interface

This block is a serial slave that gives a host read and write access to a small register file. The host frames each access with an active-low chip select and sends exactly sixteen bits on a serial data line, one bit per rising edge of its serial clock. The first byte is a command that carries the direction and a five-bit register address. The second byte carries the write data, or is a dummy byte during a read while the block shifts the addressed register's contents back on the serial output.

The register file has two banks that share the same five-bit address space. A pointer register, which can be reached at address 0x1F from either bank, selects the bank that the other addresses decode into. The primary bank holds one read-only identification register, one write-only register that restores every writable register to its default, and twenty read/write registers. The expanded bank holds sixteen read/write registers.

All serial pins are brought into the system clock domain through synchronizers and edge detectors. The serial clock must therefore be much slower than the system clock: each serial clock phase must last at least six system clock cycles.

Top module: `shreg_serial_regs`

## Requirements
- R1: A frame is the bits sampled on the rising edges of `sclk` while `cs_n` is low, taken least significant bit first. Bit 0 is the direction (1 = read, 0 = write). Bits 1 to 5 form the register address, with bit 1 as the address LSB. Bits 6 and 7 are ignored. Bits 8 to 15 are data bits D0 to D7.
- R2: A write frame updates the addressed read/write register with D7..D0 once its sixteenth rising edge has been taken in.
- R3: In a read frame, `sdo` presents D0 of the addressed register after the falling edge that follows the eighth rising edge, and D1 to D7 after each of the next seven falling edges. The host samples `sdo` on its rising edges. The data bits the host sends during a read are ignored.
- R4: `sdo` is 0 whenever `cs_n` is high and throughout every write frame.
- R5: If `cs_n` rises before the sixteenth rising edge, the frame is dropped and no register changes.
- R6: While pointer bit 0 is 0, addresses 0x01 to 0x15 other than 0x0A are read/write registers that reset to 0x00.
- R7: Address 0x00 in the primary bank always reads 0xA5, and writes to it have no effect.
- R8: Address 0x0A in the primary bank reads 0x00. Any write to it returns every read/write register in both banks, including the pointer, to 0x00.
- R9: Address 0x1F is the pointer register in both banks. It is read/write and resets to 0x00. While pointer bit 0 is 1, addresses 0x00 to 0x0F are expanded read/write registers that reset to 0x00 and are held apart from the primary registers.
- R10: Unmapped addresses (primary 0x16 to 0x1E, expanded 0x10 to 0x1E) read 0x00, and writes to them have no effect.
- R11: A synchronous active-high `rst` sets every register to 0x00, abandons any frame in progress and drives `sdo` to 0.
- R12: Rising edges after the sixteenth, within the same chip-select window, are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Host serial clock, idles low |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |

## Verification
The assertions assume that `sclk`, `cs_n` and `sdi` are slow against `clk`, so that a rising edge and a falling edge of the synchronized serial clock never fall in the same system cycle. They also assume that `sdi` changes only on falling serial edges. The bench keeps within these limits: it moves `sdi` and `sclk` only on falling system-clock edges, holds each serial phase for eight system cycles, and waits several phases around every `cs_n` change. Under these conditions the write strobe, the pointer and soft-reset behaviour, and the quiet `sdo` checks depend only on frame content.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  localparam int SH_ADDR_W      = 5;
  localparam int SH_DATA_W      = 8;
  localparam int SH_CMD_W       = 8;
  localparam int SH_SYNC_STAGES = 2;
  localparam int SH_PRIM_CNT    = 22;
  localparam int SH_EXP_CNT     = 16;
  localparam int SH_PTR_ADDR    = 31;
  localparam int SH_ID_ADDR     = 0;
  localparam int SH_SRST_ADDR   = 10;
endpackage

// File: rtl/shreg_sync.sv
module shreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic sdi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic sdi_s
);
  logic [STAGES-1:0] sclk_q, csn_q, sdi_q;
  logic              sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      csn_q  <= '1;
      sdi_q  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
      csn_q  <= {csn_q[STAGES-2:0], cs_n_i};
      sdi_q  <= {sdi_q[STAGES-2:0], sdi_i};
      sclk_d <= sclk_q[STAGES-1];
    end
  end

  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_d;
  assign sclk_fall = ~sclk_q[STAGES-1] & sclk_d;
  assign cs_act    = ~csn_q[STAGES-1];
  assign sdi_s     = sdi_q[STAGES-1];
endmodule

// File: rtl/shreg_frame.sv
module shreg_frame #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          sdi_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sdo
);
  localparam int FW   = CW + DW;
  localparam int CNTW = $clog2(FW + 1);
  localparam logic [CNTW-1:0] CMD_TOP   = CNTW'(AW);
  localparam logic [CNTW-1:0] CMD_LAST  = CNTW'(CW - 1);
  localparam logic [CNTW-1:0] DAT_FIRST = CNTW'(CW);
  localparam logic [CNTW-1:0] FRM_LAST  = CNTW'(FW - 1);
  localparam logic [CNTW-1:0] FRM_DONE  = CNTW'(FW);

  logic [CNTW-1:0] cnt;
  logic [AW:0]     cmd_q;   // [0] direction, [AW:1] address
  logic [DW-2:0]   dat_q;   // D0..D(DW-2), last bit joins at commit
  logic [DW-1:0]   txsr;
  logic            rd_act;

  assign rd_addr = cmd_q[AW:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cmd_q   <= '0;
      dat_q   <= '0;
      txsr    <= '0;
      rd_act  <= 1'b0;
      sdo     <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!cs_act) begin
        cnt    <= '0;
        rd_act <= 1'b0;
        sdo    <= 1'b0;
      end else begin
        if (sclk_rise && cnt != FRM_DONE) begin
          cnt <= cnt + 1'b1;
          if (cnt <= CMD_TOP)
            cmd_q <= {sdi_s, cmd_q[AW:1]};
          if (cnt >= DAT_FIRST && cnt < FRM_LAST)
            dat_q <= {sdi_s, dat_q[DW-2:1]};
          if (cnt == CMD_LAST && cmd_q[0]) begin
            txsr   <= rd_data;
            rd_act <= 1'b1;
          end
          if (cnt == FRM_LAST && !cmd_q[0]) begin
            wr_en   <= 1'b1;
            wr_addr <= cmd_q[AW:1];
            wr_data <= {sdi_s, dat_q};
          end
        end
        if (sclk_fall && rd_act) begin
          if (cnt == FRM_DONE) begin
            sdo    <= 1'b0;
            rd_act <= 1'b0;
          end else if (cnt >= DAT_FIRST) begin
            sdo  <= txsr[0];
            txsr <= txsr >> 1;
          end
        end
      end
    end
  end

  // R5: a write strobe only exists once the full frame has been counted
  p_wr_full_frame_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> cnt == FRM_DONE);
  // R4: outside an active read the serial output is quiet
  p_sdo_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_act |-> !sdo);
  // R12: the bit counter never passes the frame length
  p_cnt_bound_r12: assert property (@(posedge clk) disable iff (rst)
    cnt <= FRM_DONE);
endmodule

// File: rtl/shreg_regfile.sv
module shreg_regfile #(
  parameter int AW        = 5,
  parameter int DW        = 8,
  parameter int PRIM_CNT  = 22,
  parameter int EXP_CNT   = 16,
  parameter int PTR_ADDR  = 31,
  parameter int ID_ADDR   = 0,
  parameter int SRST_ADDR = 10,
  parameter logic [DW-1:0] ID_VALUE = 'hA5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int PIW = $clog2(PRIM_CNT);
  localparam int EIW = $clog2(EXP_CNT);

  logic [DW-1:0] prim_q [PRIM_CNT];
  logic [DW-1:0] exp_q  [EXP_CNT];
  logic [DW-1:0] ptr_q;
  logic          exp_sel;
  logic          srst_hit;

  assign exp_sel  = ptr_q[0];
  assign srst_hit = wr_en && !exp_sel && (wr_addr == AW'(SRST_ADDR));

  always_ff @(posedge clk) begin
    if (rst || srst_hit) begin
      ptr_q <= '0;
      for (int i = 0; i < PRIM_CNT; i++) prim_q[i] <= '0;
      for (int j = 0; j < EXP_CNT; j++)  exp_q[j]  <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(PTR_ADDR)) begin
        ptr_q <= wr_data;
      end else if (exp_sel) begin
        if (int'(wr_addr) < EXP_CNT) exp_q[wr_addr[EIW-1:0]] <= wr_data;
      end else if (wr_addr != AW'(ID_ADDR) && int'(wr_addr) < PRIM_CNT) begin
        prim_q[wr_addr[PIW-1:0]] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(PTR_ADDR)) begin
      rd_data = ptr_q;
    end else if (exp_sel) begin
      if (int'(rd_addr) < EXP_CNT) rd_data = exp_q[rd_addr[EIW-1:0]];
    end else if (rd_addr == AW'(ID_ADDR)) begin
      rd_data = ID_VALUE;
    end else if (rd_addr != AW'(SRST_ADDR) && int'(rd_addr) < PRIM_CNT) begin
      rd_data = prim_q[rd_addr[PIW-1:0]];
    end
  end

  // R9: a pointer write lands exactly
  p_ptr_write_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(PTR_ADDR)) |=> ptr_q == $past(wr_data));
  // R8: soft reset clears the pointer
  p_soft_reset_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ptr_q[0] && wr_addr == AW'(SRST_ADDR)) |=> ptr_q == '0);
  // R10: unmapped primary addresses read zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (!ptr_q[0] && int'(rd_addr) >= PRIM_CNT && rd_addr != AW'(PTR_ADDR))
      |-> rd_data == '0);
endmodule

// File: rtl/shreg_serial_regs.sv
module shreg_serial_regs
  import shreg_pkg::*;
#(
  parameter int AW          = SH_ADDR_W,
  parameter int DW          = SH_DATA_W,
  parameter int CW          = SH_CMD_W,
  parameter int SYNC_STAGES = SH_SYNC_STAGES,
  parameter logic [DW-1:0] ID_VALUE = 'hA5
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sdo
);
  logic          sclk_rise, sclk_fall, cs_act, sdi_s;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;

  shreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .sdi_s(sdi_s)
  );

  shreg_frame #(.AW(AW), .DW(DW), .CW(CW)) u_frame (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .sdi_s(sdi_s), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sdo(sdo)
  );

  shreg_regfile #(
    .AW(AW), .DW(DW), .PRIM_CNT(SH_PRIM_CNT), .EXP_CNT(SH_EXP_CNT),
    .PTR_ADDR(SH_PTR_ADDR), .ID_ADDR(SH_ID_ADDR), .SRST_ADDR(SH_SRST_ADDR),
    .ID_VALUE(ID_VALUE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/sim_shreg_serial_regs.sv
`timescale 1ns/1ps
module sim_shreg_serial_regs;
  localparam int H = 8;  // system cycles per serial phase

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic sdi = 1'b0;
  logic sdo;

  int tests = 0;
  int fails = 0;
  int quiet_err = 0;
  bit quiet = 1'b0;

  // behavioural reference state
  int m_prim [32];
  int m_exp  [32];
  int m_ptr;

  always #10 clk = ~clk;  // 50 MHz

  shreg_serial_regs u0 (.clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo));

  // every-clock comparison of the quiet output (R4)
  always @(negedge clk) if (quiet && sdo !== 1'b0) quiet_err++;

  function automatic int m_read(int a);
    if (a == 31) return m_ptr;
    if ((m_ptr & 1) != 0) return (a < 16) ? m_exp[a] : 0;
    if (a == 0) return 'hA5;
    if (a == 10) return 0;
    if (a < 22) return m_prim[a];
    return 0;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < 32; i++) begin m_prim[i] = 0; m_exp[i] = 0; end
    m_ptr = 0;
  endtask

  task automatic m_write(int a, int d);
    if (a == 31) m_ptr = d;
    else if ((m_ptr & 1) != 0) begin if (a < 16) m_exp[a] = d; end
    else if (a == 10) m_clear();
    else if (a != 0 && a < 22) m_prim[a] = d;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] dat,
                      input int nrise, output logic [7:0] got);
    got = '0;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nrise; i++) begin
      sdi = (i < 8) ? cmd[i] : (i < 16) ? dat[i-8] : 1'b1;
      repeat (H) @(negedge clk);
      if (i >= 8 && i < 16) got[i-8] = sdo;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    sdi = 1'b0;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    logic [7:0] g;
    xfer({2'b00, 5'(a), 1'b0}, 8'(d), 16, g);
    m_write(a, d);
  endtask

  task automatic rd_chk(int a, string tag);
    logic [7:0] g;
    quiet = 1'b0;
    xfer({2'b00, 5'(a), 1'b1}, 8'h00, 16, g);
    quiet = 1'b1;
    check(int'(g) == m_read(a), tag, int'(g), m_read(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] g;
    m_clear();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(sdo == 1'b0, "R11 sdo after reset", int'(sdo), 0);
    quiet = 1'b1;

    rd_chk(0, "R7 id read");
    check(m_read(0) == 'hA5, "R7 id constant", m_read(0), 'hA5);
    rd_chk(5, "R11 reg default");

    wr(5, 'h3C);  rd_chk(5, "R2 write 0x05");
    wr(21, 'h81); rd_chk(21, "R6 write 0x15");
    wr(1, 'hFF);  rd_chk(1, "R6 write 0x01");
    wr(0, 'hFF);  rd_chk(0, "R7 id write ignored");
    rd_chk(10, "R8 soft reset reads zero");
    wr(22, 'h77); rd_chk(22, "R10 unmapped 0x16");
    rd_chk(30, "R10 unmapped 0x1E");

    wr(31, 'h01); rd_chk(31, "R9 pointer readback");
    wr(5, 'h5A);  rd_chk(5, "R9 expanded 0x05");
    wr(10, 'h42); rd_chk(10, "R9 expanded 0x0A not reset");
    wr(16, 'h33); rd_chk(16, "R10 expanded unmapped 0x10");
    wr(31, 'h00); rd_chk(5, "R9 primary kept apart");

    // aborted writes
    xfer({2'b00, 5'd5, 1'b0}, 8'h11, 12, g);
    rd_chk(5, "R5 abort after 12 bits");
    xfer({2'b00, 5'd5, 1'b0}, 8'h11, 15, g);
    rd_chk(5, "R5 abort after 15 bits");
    check(m_read(5) == 'h3C, "R5 model holds", m_read(5), 'h3C);

    // extra rising edges
    xfer({2'b00, 5'd7, 1'b0}, 8'h99, 20, g); m_write(7, 'h99);
    rd_chk(7, "R12 extra edges ignored");

    // ignored command bits and ignored read data byte
    xfer({2'b11, 5'd9, 1'b0}, 8'h6E, 16, g); m_write(9, 'h6E);
    rd_chk(9, "R1 ignored command bits");
    quiet = 1'b0;
    xfer({2'b10, 5'd9, 1'b1}, 8'hFF, 16, g);
    quiet = 1'b1;
    check(g == 8'h6E, "R3 read with dummy byte", int'(g), 'h6E);

    // soft reset
    wr(31, 'h01); wr(3, 'h27); wr(31, 'h00);
    wr(10, 'hAB);
    rd_chk(5, "R8 primary cleared");
    rd_chk(31, "R8 pointer cleared");
    wr(31, 'h01); rd_chk(3, "R8 expanded cleared");
    rd_chk(10, "R8 expanded 0x0A cleared");
    wr(31, 'h00);

    // hardware reset
    wr(21, 'h5F); wr(31, 'h01);
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
    m_clear(); repeat (4) @(negedge clk);
    rd_chk(21, "R11 register cleared");
    rd_chk(31, "R11 pointer cleared");

    check(quiet_err == 0, "R4 sdo quiet per clock", quiet_err, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule